// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block keeps a pending-event word and an enable word for the interrupt sources of a small processor subsystem. It raises a single request line toward the CPU. Peripherals pulse event inputs, and each pulse latches one pending bit. Three peripherals have fixed positions in that word: the DMA engine, the serial port and the sound unit. All other sources arrive on a generic event vector.

Software reads both words through the I/O page. It acknowledges events by writing to the pending word. The new pending value is the old value ANDed with the written data and with the current enable word. A write therefore clears every bit written as zero, and it also clears every bit that is currently disabled.

The request line is the OR of the pending bits that are enabled. It is formed directly from the two registers. A write to the enable word that exposes an already-pending bit raises the request in the next cycle, with no new event needed.

Top module: `irq_stat_mask_ctl`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears the pending word and the enable word, and irq_o is 0 while they are clear.
- R2: The pending word is at byte offset 0x070 and the enable word at 0x074. rd_data_o returns the addressed word zero-extended to 32 bits. Any other offset reads 0, and a write to any other offset changes neither word.
- R3: A write to 0x070 sets the pending word to old pending AND enable word AND written data.
- R4: An event bit evt_i[i] high at a clock edge sets pending bit i, whatever the enable word holds. The bit then stays set until an acknowledge clears it.
- R5: dma_evt_i sets pending bit 3, ser_evt_i sets pending bit 7 and snd_evt_i sets pending bit 9.
- R6: irq_o is 1 exactly when some bit is set in both the pending word and the enable word. When a write to the enable word covers a pending bit, irq_o is 1 in the cycle after that write's clock edge.
- R7: When an event bit and an acknowledge write that clears the same bit fall on the same clock edge, the bit ends set.
- R8: A 16-bit write (wr_wide_i=0, data in wr_data_i[15:0]) and a 32-bit write (wr_wide_i=1) give the same result on the low 16 bits. Bits 31:16 of a write never affect the 16-bit words.
- R9: A write to 0x074 loads the enable word from the written data and leaves the pending word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_wide_i | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| wr_addr_i | input | 12 | Byte offset of the write in the I/O page |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 12 | Byte offset of the read |
| rd_data_o | output | 32 | Read data, combinational |
| evt_i | input | 16 | Generic event pulses, one per pending bit |
| dma_evt_i | input | 1 | DMA controller event |
| ser_evt_i | input | 1 | Serial port event |
| snd_evt_i | input | 1 | Sound unit event |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
An acknowledge write and an incoming event can land on the same clock edge, and they can target the same pending bit. The vector table drives an acknowledge of zero to 0x070 while the event for the bit being cleared is high, in the same cycle. The bit is then read back through the port, and the bench checks that the event won and that irq_o follows the enable word. A second collision appears in the table as well: an enable write that uncovers an already-pending bit, with irq_o checked in the cycle after that edge.

// File: rtl/irq_sm_pkg.sv
package irq_sm_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_STAT = 2'd1,
      ACC_MASK = 2'd2
   } acc_sel_e;

   localparam int unsigned BUS_W  = 32;
   localparam int unsigned HALF_W = 16;

endpackage

// File: rtl/irq_sm_decode.sv
module irq_sm_decode
   import irq_sm_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 16,
   parameter int unsigned ADDR_W   = 12,
   parameter logic [11:0] STAT_OFS = 12'h070,
   parameter logic [11:0] MASK_OFS = 12'h074
) (
   input  logic                wr_en_i,
   input  logic                wr_wide_i,
   input  logic [ADDR_W-1:0]   wr_addr_i,
   input  logic [BUS_W-1:0]    wr_data_i,
   output acc_sel_e            sel_o,
   output logic [NUM_SRC-1:0]  wval_o
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

   logic unused_lane;

   always_comb begin
      sel_o = ACC_NONE;
      if (wr_en_i && wr_addr_i == STAT_A) sel_o = ACC_STAT;
      else if (wr_en_i && wr_addr_i == MASK_A) sel_o = ACC_MASK;
   end

   generate
      if (NUM_SRC <= HALF_W) begin : g_narrow
         assign wval_o = wr_data_i[NUM_SRC-1:0];
      end else begin : g_wide
         assign wval_o = wr_wide_i ? wr_data_i[NUM_SRC-1:0]
                                   : {{(NUM_SRC-HALF_W){1'b0}}, wr_data_i[HALF_W-1:0]};
      end
   endgenerate

   assign unused_lane = ^{wr_data_i, wr_wide_i};

endmodule

// File: rtl/irq_sm_evt_merge.sv
module irq_sm_evt_merge #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned DMA_BIT = 3,
   parameter int unsigned SER_BIT = 7,
   parameter int unsigned SND_BIT = 9
) (
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               dma_evt_i,
   input  logic               ser_evt_i,
   input  logic               snd_evt_i,
   output logic [NUM_SRC-1:0] set_o
);

   generate
      for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
         logic hw_evt;
         if (b == DMA_BIT) begin : g_dma
            assign hw_evt = dma_evt_i;
         end else if (b == SER_BIT) begin : g_ser
            assign hw_evt = ser_evt_i;
         end else if (b == SND_BIT) begin : g_snd
            assign hw_evt = snd_evt_i;
         end else begin : g_none
            assign hw_evt = 1'b0;
         end
         assign set_o[b] = evt_i[b] | hw_evt;
      end
   endgenerate

endmodule

// File: rtl/irq_sm_regs.sv
module irq_sm_regs
   import irq_sm_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  acc_sel_e           sel_i,
   input  logic [NUM_SRC-1:0] wval_i,
   input  logic [NUM_SRC-1:0] set_i,
   output logic [NUM_SRC-1:0] stat_o,
   output logic [NUM_SRC-1:0] mask_o
);

   logic [NUM_SRC-1:0] stat_q, mask_q, stat_keep;

   // acknowledge keeps only bits that are both enabled and written as one
   assign stat_keep = (sel_i == ACC_STAT) ? (stat_q & mask_q & wval_i) : stat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_q <= '0;
      end else begin
         stat_q <= stat_keep | set_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '0;
      end else if (sel_i == ACC_MASK) begin
         mask_q <= wval_i;
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;

endmodule

// File: rtl/irq_stat_mask_ctl.sv
module irq_stat_mask_ctl
   import irq_sm_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 16,
   parameter int unsigned ADDR_W   = 12,
   parameter logic [11:0] STAT_OFS = 12'h070,
   parameter logic [11:0] MASK_OFS = 12'h074,
   parameter int unsigned DMA_BIT  = 3,
   parameter int unsigned SER_BIT  = 7,
   parameter int unsigned SND_BIT  = 9
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic               wr_wide_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [31:0]        wr_data_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   output logic [31:0]        rd_data_o,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               dma_evt_i,
   input  logic               ser_evt_i,
   input  logic               snd_evt_i,
   output logic               irq_o
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

   generate
      if (NUM_SRC < 1 || NUM_SRC > BUS_W) begin : g_bad_width
         $error("NUM_SRC out of range");
      end
      if (DMA_BIT >= NUM_SRC || SER_BIT >= NUM_SRC || SND_BIT >= NUM_SRC) begin : g_bad_bit
         $error("fixed source bit beyond NUM_SRC");
      end
      if (STAT_OFS == MASK_OFS || STAT_OFS[1:0] != 2'b00 || MASK_OFS[1:0] != 2'b00) begin : g_bad_ofs
         $error("register offsets must differ and be word aligned");
      end
      if (ADDR_W > 12 || ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
   endgenerate

   acc_sel_e           sel;
   logic [NUM_SRC-1:0] wval, set_vec, stat_q, mask_q;

   irq_sm_decode #(
      .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
   ) dec_i (
      .wr_en_i(wr_en_i), .wr_wide_i(wr_wide_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .sel_o(sel), .wval_o(wval)
   );

   irq_sm_evt_merge #(
      .NUM_SRC(NUM_SRC), .DMA_BIT(DMA_BIT), .SER_BIT(SER_BIT), .SND_BIT(SND_BIT)
   ) merge_i (
      .evt_i(evt_i), .dma_evt_i(dma_evt_i), .ser_evt_i(ser_evt_i),
      .snd_evt_i(snd_evt_i), .set_o(set_vec)
   );

   irq_sm_regs #(
      .NUM_SRC(NUM_SRC)
   ) regs_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .wval_i(wval),
      .set_i(set_vec), .stat_o(stat_q), .mask_o(mask_q)
   );

   assign irq_o = |(stat_q & mask_q);

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == STAT_A)      rd_data_o = BUS_W'(stat_q);
      else if (rd_addr_i == MASK_A) rd_data_o = BUS_W'(mask_q);
   end

endmodule

// File: rtl/irq_sm_chk.sv
module irq_sm_chk
   import irq_sm_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16
) (
   input logic               clk_i,
   input logic               rst_ni,
   input acc_sel_e           sel,
   input logic [NUM_SRC-1:0] wval,
   input logic [NUM_SRC-1:0] set_vec,
   input logic [NUM_SRC-1:0] stat_q,
   input logic [NUM_SRC-1:0] mask_q,
   input logic               irq_o
);

   // R1: a clock edge seen in reset leaves both words clear and no request
   p_reset_clear_r1: assert property (@(posedge clk_i)
      !rst_ni |=> (stat_q == '0 && mask_q == '0 && !irq_o));

   // R3: acknowledge with no event present
   p_ack_and_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == ACC_STAT && set_vec == '0) |=> stat_q == $past(stat_q & mask_q & wval));

   // R4 and R7: every event bit is set after its edge, whatever else happens
   p_event_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

   // R9: an enable write leaves pending bits alone when no event arrives
   p_mask_keeps_stat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == ACC_MASK && set_vec == '0) |=> $stable(stat_q));

   // R6: an enable write that covers a pending bit raises the request next cycle
   p_mask_raises_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == ACC_MASK && (stat_q & wval) != '0) |=> irq_o);

endmodule

bind irq_stat_mask_ctl irq_sm_chk #(.NUM_SRC(NUM_SRC)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .sel(sel), .wval(wval), .set_vec(set_vec),
   .stat_q(stat_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/irq_stat_mask_ctl_tb.sv
module irq_stat_mask_ctl_tb_top;

   localparam logic [11:0] A_STAT = 12'h070;
   localparam logic [11:0] A_MASK = 12'h074;

   typedef struct packed {
      logic [1:0]  op;    // 0 idle, 1 write pending word, 2 write enable word
      logic        wide;
      logic [31:0] data;
      logic [15:0] evt;
      logic [15:0] xs;
      logic [15:0] xm;
      logic        xi;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VT [NV] = '{
      '{2'd0, 1'b0, 32'h0000_0000, 16'h0005, 16'h0005, 16'h0000, 1'b0}, // R4 unmasked event
      '{2'd2, 1'b1, 32'hFFFF_0004, 16'h0000, 16'h0005, 16'h0004, 1'b1}, // R6 R8 R9
      '{2'd1, 1'b1, 32'hFFFF_FFFF, 16'h0000, 16'h0004, 16'h0004, 1'b1}, // R3 disabled bit dropped
      '{2'd1, 1'b0, 32'h0000_0000, 16'h0004, 16'h0004, 16'h0004, 1'b1}, // R7 event beats ack
      '{2'd2, 1'b0, 32'h0000_0F0F, 16'h0000, 16'h0004, 16'h0F0F, 1'b1}, // R9 narrow mask
      '{2'd0, 1'b0, 32'h0000_0000, 16'h00F0, 16'h00F4, 16'h0F0F, 1'b1}, // R4
      '{2'd1, 1'b0, 32'h0000_00F0, 16'h0000, 16'h0000, 16'h0F0F, 1'b0}, // R3 R8 narrow ack
      '{2'd0, 1'b0, 32'h0000_0000, 16'h8000, 16'h8000, 16'h0F0F, 1'b0}, // R4 R6 masked off
      '{2'd2, 1'b1, 32'h0000_8000, 16'h0000, 16'h8000, 16'h8000, 1'b1}, // R6 uncover pending
      '{2'd1, 1'b1, 32'hABCD_7FFF, 16'h0000, 16'h0000, 16'h8000, 1'b0}  // R3 R8 upper ignored
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_wide = 1'b0;
   logic [11:0] wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, rd_data;
   logic [15:0] evt = '0;
   logic        dma_evt = 1'b0, ser_evt = 1'b0, snd_evt = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irq_stat_mask_ctl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_wide_i(wr_wide),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .evt_i(evt), .dma_evt_i(dma_evt),
      .ser_evt_i(ser_evt), .snd_evt_i(snd_evt), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      wr_en = 1'b0; wr_wide = 1'b0; wr_addr = '0; wr_data = '0;
      evt = '0; dma_evt = 1'b0; ser_evt = 1'b0; snd_evt = 1'b0;
   endtask

   // called in the low phase: reads both words and the request
   task automatic look(input string req, input logic [15:0] xs, input logic [15:0] xm,
                       input logic xi);
      rd_addr = A_STAT; #1;
      chk({req, " pending"}, rd_data, {16'h0, xs});
      rd_addr = A_MASK; #1;
      chk({req, " enable"}, rd_data, {16'h0, xm});
      chk({req, " irq"}, {31'h0, irq}, {31'h0, xi});
   endtask

   // drive in the low phase, let one edge pass, return to the low phase
   task automatic cycle();
      @(posedge clk); #2;
      idle_inputs();
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      // R1: words clear during reset
      look("R1 reset", 16'h0, 16'h0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         wr_en   = (VT[i].op != 2'd0);
         wr_addr = (VT[i].op == 2'd2) ? A_MASK : A_STAT;
         wr_wide = VT[i].wide;
         wr_data = VT[i].data;
         evt     = VT[i].evt;
         cycle();
         look($sformatf("R3/R4/R6/R7/R8/R9 vector %0d", i), VT[i].xs, VT[i].xm, VT[i].xi);
      end

      // R5: fixed sources land on bits 3, 7, 9
      wr_en = 1'b1; wr_addr = A_MASK; wr_data = 32'h0000_FFFF; cycle();
      dma_evt = 1'b1; cycle();
      look("R5 dma bit 3", 16'h0008, 16'hFFFF, 1'b1);
      ser_evt = 1'b1; cycle();
      look("R5 serial bit 7", 16'h0088, 16'hFFFF, 1'b1);
      snd_evt = 1'b1; cycle();
      look("R5 sound bit 9", 16'h0288, 16'hFFFF, 1'b1);

      // R2: writes elsewhere ignored, reads elsewhere give zero
      wr_en = 1'b1; wr_wide = 1'b1; wr_addr = 12'h078; wr_data = 32'h0; cycle();
      wr_en = 1'b1; wr_wide = 1'b0; wr_addr = 12'h072; wr_data = 32'h0; cycle();
      look("R2 off-address write", 16'h0288, 16'hFFFF, 1'b1);
      rd_addr = 12'h078; #1;
      chk("R2 off-address read", rd_data, 32'h0);

      // R6: disabling the only pending bits drops the request
      wr_en = 1'b1; wr_addr = A_MASK; wr_data = 32'h0000_FC77; cycle();
      look("R6 mask removes request", 16'h0288, 16'hFC77, 1'b0);

      // R1: asynchronous reset in mid run
      #1 rst_n = 1'b0; #1;
      look("R1 mid-run reset", 16'h0, 16'h0, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule